// File: doc/BRIEF.md
# Ordered Debug Event Trigger

This block turns up to three independent comparator match pulses into one ordered trigger. Each channel input carries a one-cycle pulse from an address, data or bus-state comparator that sits outside the block. Software picks an ordering mode and an action. A trigger fires only when the channel pulses arrive in the order that the mode requires. The trigger becomes either a break request or an internal-trace halt request.

Two features go beyond a plain sequencer. The first is an optional reset-point channel. When it is enabled, it throws away any partial progress through the sequence. The second is a repeat count on the final stage. The output fires only after the whole sequence has completed the programmed number of times.

A synchronous system-reset event input clears all progress and discards any match that arrives in the same cycle. While software rewrites the configuration, it holds a rewrite flag high. During that time every channel is masked.

Top module: `ordered_event_trigger`

## Requirements
- R1: With `cfgMode` = 1 (three-stage), a trigger fires only after pulses on channel 3, then channel 2, then channel 1, each accepted in a separate cycle.
- R2: With `cfgMode` = 2 (two-stage), a trigger fires after channel 2 then channel 1. Channel 3 has no effect in this mode.
- R3: A pulse on a channel other than the one currently expected is ignored. It neither advances nor clears progress.
- R4: When `cfgRstPtEn` = 1, a `matchRstPt` pulse returns the sequence to its first stage. This gives the reset point priority over a coincident channel match. When `cfgRstPtEn` = 0, `matchRstPt` has no effect.
- R5: The trigger fires on the Nth completion of the full sequence, where N = `cfgRepeat`. A `cfgRepeat` of 0 behaves as 1. Completions are counted from the last trigger, the last system reset or the last time the mode was off. A reset point does not clear the count.
- R6: A trigger is a one-cycle pulse. It appears in the clock cycle after the cycle that accepts the final channel 1 match. It goes on `breakReq` when `cfgAction` = 0 and on `traceHaltReq` when `cfgAction` = 1, and never on both.
- R7: A cycle with `sysReset` = 1 accepts no match. That cycle also clears both stage progress and the completion count.
- R8: While `cfgUpdate` = 1, no channel or reset-point pulse is accepted. Progress and the completion count are kept.
- R9: `cfgMode` = 0, and the unused code 3, turn the block off. No trigger fires, and progress and the count are held cleared.
- R10: After a trigger, the sequence is back at its first stage and the count is zero. A lone channel 1 pulse right after a trigger does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sysReset | input | 1 | Synchronous system-reset event; clears progress, masks matches that cycle |
| cfgMode | input | 2 | 0 off, 1 three-stage (3,2,1), 2 two-stage (2,1), 3 off |
| cfgRstPtEn | input | 1 | Enables the reset-point channel |
| cfgRepeat | input | CNT_W | Required number of full-sequence completions (0 behaves as 1) |
| cfgAction | input | 1 | 0 routes the trigger to break, 1 to trace halt |
| cfgUpdate | input | 1 | Configuration rewrite in progress; masks all channels |
| matchC1 | input | 1 | Channel 1 match pulse (final stage) |
| matchC2 | input | 1 | Channel 2 match pulse |
| matchC3 | input | 1 | Channel 3 match pulse |
| matchRstPt | input | 1 | Reset-point match pulse |
| breakReq | output | 1 | One-cycle break request |
| traceHaltReq | output | 1 | One-cycle internal-trace halt request |

## Verification
The bench feeds out-of-order pulses at each stage. A design that reset progress on a stray pulse would miss the later trigger. A design that accepted the pulse would fire early.

It places a reset point between stage 2 and stage 1, both enabled and disabled. A design that ignored the enable would fire wrongly in one case and stay silent in the other.

It counts repeated completions with the repeat count set to three and to zero. An off-by-one counter, or one that treats zero literally, fires on the wrong pass.

It also lands a final-stage pulse on a system-reset cycle and on a rewrite cycle, and then sends a lone channel 1 pulse right after a trigger. A missing mask, a rewrite that wrongly clears progress, or stale state after firing each shows up as an extra or missing pulse.

// File: rtl/oet_pkg.sv
package oet_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_THREE = 2'd1,
    MODE_TWO   = 2'd2,
    MODE_RSVD  = 2'd3
  } seqMode_e;

  // strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic passDone;  // final stage accepted this cycle
    logic clearAll;  // drop the completion count
  } seqStrobe_t;

endpackage

// File: rtl/oet_ctrl.sv
module oet_ctrl
  import oet_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysReset,
  input  logic [1:0] cfgMode,
  input  logic       cfgRstPtEn,
  input  logic       cfgUpdate,
  input  logic [2:0] chanHit,    // {ch3, ch2, ch1}
  input  logic       rstPtHit,
  output seqStrobe_t strobe
);

  localparam int STAGE_W = 2;

  logic [STAGE_W-1:0] stage, stageNext;
  logic [STAGE_W-1:0] lastStage;
  logic [STAGE_W-1:0] chanIdx;
  logic               active, stale, gate, abort, expHit, advance, isLast;

  always_comb begin
    active    = (cfgMode == MODE_THREE) || (cfgMode == MODE_TWO);
    lastStage = (cfgMode == MODE_THREE) ? STAGE_W'(2) : STAGE_W'(1);
    stale     = stage > lastStage;
    chanIdx   = lastStage - stage;
    expHit    = !stale && chanHit[chanIdx];
    isLast    = stage == lastStage;
    gate      = active && !cfgUpdate && !sysReset;
    abort     = gate && cfgRstPtEn && rstPtHit;
    advance   = gate && expHit && !abort;
    strobe.passDone = advance && isLast;
    strobe.clearAll = sysReset || !active;
  end

  always_comb begin
    stageNext = stage;
    if (strobe.clearAll || stale || abort || strobe.passDone)
      stageNext = '0;
    else if (advance)
      stageNext = stage + STAGE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= stageNext;
  end

endmodule

// File: rtl/oet_count.sv
module oet_count
  import oet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] cfgRepeat,
  input  logic             cfgAction,
  output logic             breakReq,
  output logic             traceHaltReq
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] passCnt;
  logic [SUM_W-1:0] passNext, target;
  logic             reached, fireQ, actQ;

  always_comb begin
    target   = (cfgRepeat == '0) ? SUM_W'(1) : {1'b0, cfgRepeat};
    passNext = {1'b0, passCnt} + SUM_W'(1);
    reached  = passNext >= target;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passCnt <= '0;
      fireQ   <= 1'b0;
      actQ    <= 1'b0;
    end else begin
      fireQ <= 1'b0;
      if (strobe.clearAll) begin
        passCnt <= '0;
      end else if (strobe.passDone) begin
        if (reached) begin
          fireQ   <= 1'b1;
          actQ    <= cfgAction;
          passCnt <= '0;
        end else begin
          passCnt <= passNext[CNT_W-1:0];
        end
      end
    end
  end

  assign breakReq     = fireQ && !actQ;
  assign traceHaltReq = fireQ && actQ;

endmodule

// File: rtl/ordered_event_trigger.sv
module ordered_event_trigger
  import oet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sysReset,
  input  logic [1:0]       cfgMode,
  input  logic             cfgRstPtEn,
  input  logic [CNT_W-1:0] cfgRepeat,
  input  logic             cfgAction,
  input  logic             cfgUpdate,
  input  logic             matchC1,
  input  logic             matchC2,
  input  logic             matchC3,
  input  logic             matchRstPt,
  output logic             breakReq,
  output logic             traceHaltReq
);

  seqStrobe_t strobe;

  oet_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sysReset   (sysReset),
    .cfgMode    (cfgMode),
    .cfgRstPtEn (cfgRstPtEn),
    .cfgUpdate  (cfgUpdate),
    .chanHit    ({matchC3, matchC2, matchC1}),
    .rstPtHit   (matchRstPt),
    .strobe     (strobe)
  );

  oet_count #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgRepeat    (cfgRepeat),
    .cfgAction    (cfgAction),
    .breakReq     (breakReq),
    .traceHaltReq (traceHaltReq)
  );

endmodule

// File: rtl/oet_checker.sv
module oet_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sysReset,
  input logic [1:0] cfgMode,
  input logic       cfgRstPtEn,
  input logic       cfgUpdate,
  input logic       matchC1,
  input logic       matchRstPt,
  input logic       breakReq,
  input logic       traceHaltReq
);

  logic fire;
  assign fire = breakReq || traceHaltReq;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(breakReq && traceHaltReq));                                   // R6

  AST_BREAK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> !breakReq);                                        // R10

  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    traceHaltReq |=> !traceHaltReq);                                // R6

  AST_FINAL_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> $past(matchC1));                                       // R1

  AST_RSTPT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> !($past(cfgRstPtEn) && $past(matchRstPt)));            // R4

  AST_SYSRST_MASK: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> !$past(sysReset));                                     // R7

  AST_UPDATE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> !$past(cfgUpdate));                                    // R8

  AST_MODE_ON: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> ($past(cfgMode) == 2'd1 || $past(cfgMode) == 2'd2));   // R9

endmodule

bind ordered_event_trigger oet_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sysReset     (sysReset),
  .cfgMode      (cfgMode),
  .cfgRstPtEn   (cfgRstPtEn),
  .cfgUpdate    (cfgUpdate),
  .matchC1      (matchC1),
  .matchRstPt   (matchRstPt),
  .breakReq     (breakReq),
  .traceHaltReq (traceHaltReq)
);

// File: tb/ordered_event_trigger_tb.sv
module ordered_event_trigger_tb;

  localparam int CNT_W = 8;
  localparam logic [5:0] NONE = 6'h00, C1 = 6'h01, C2 = 6'h02, C3 = 6'h04,
                         RP = 6'h08, SR = 6'h10, UP = 6'h20;

  typedef struct {
    logic  expBrk;
    logic  expHalt;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysReset = 1'b0;
  logic [1:0] cfgMode = 2'd1;
  logic cfgRstPtEn = 1'b0;
  logic [CNT_W-1:0] cfgRepeat = 8'd1;
  logic cfgAction = 1'b0;
  logic cfgUpdate = 1'b0;
  logic matchC1 = 1'b0, matchC2 = 1'b0, matchC3 = 1'b0, matchRstPt = 1'b0;
  logic breakReq, traceHaltReq;

  int vecCnt = 0;
  int errCnt = 0;
  int cycles = 0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  ordered_event_trigger #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .sysReset(sysReset), .cfgMode(cfgMode),
    .cfgRstPtEn(cfgRstPtEn), .cfgRepeat(cfgRepeat), .cfgAction(cfgAction),
    .cfgUpdate(cfgUpdate), .matchC1(matchC1), .matchC2(matchC2),
    .matchC3(matchC3), .matchRstPt(matchRstPt), .breakReq(breakReq),
    .traceHaltReq(traceHaltReq)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  endtask

  // driver: applies one cycle of stimulus, queues the output expected after the next edge
  task automatic drive(input logic [5:0] m, input logic eb, input logic eh, input string req);
    expItem_t it;
    @(negedge clk);
    matchC1    = m[0];
    matchC2    = m[1];
    matchC3    = m[2];
    matchRstPt = m[3];
    sysReset   = m[4];
    cfgUpdate  = m[5];
    it.expBrk  = eb;
    it.expHalt = eh;
    it.req     = req;
    expQ.push_back(it);
  endtask

  task automatic clearSeq();
    drive(SR, 1'b0, 1'b0, "R7");
  endtask

  // monitor: compares outputs away from the clock edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      vecCnt++;
      if (breakReq !== it.expBrk || traceHaltReq !== it.expHalt) begin
        errCnt++;
        $display("FAIL %s: brk/halt actual %b%b expected %b%b at %0t",
                 it.req, breakReq, traceHaltReq, it.expBrk, it.expHalt, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errCnt++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    vecCnt++;
    if (breakReq !== 1'b0 || traceHaltReq !== 1'b0) begin
      errCnt++;
      $display("FAIL R6 reset: actual %b%b expected 00", breakReq, traceHaltReq);
    end
    rstN = 1'b1;

    // R1: ordered three-stage fires a break one cycle after C1
    drive(C3, 0, 0, "R1"); drive(C2, 0, 0, "R1"); drive(C1, 1, 0, "R1/R6");
    drive(NONE, 0, 0, "R6");
    // R10: lone C1 right after a trigger
    drive(C1, 0, 0, "R10"); drive(NONE, 0, 0, "R10");

    // R3: stray pulses ignored, progress kept
    drive(C1, 0, 0, "R3"); drive(C3, 0, 0, "R3"); drive(C1, 0, 0, "R3");
    drive(C2, 0, 0, "R3"); drive(C3, 0, 0, "R3"); drive(C2, 0, 0, "R3");
    drive(C1, 1, 0, "R3"); drive(NONE, 0, 0, "R3");

    // R1: wrong order does not fire
    drive(C2, 0, 0, "R1"); drive(C1, 0, 0, "R1"); drive(C3, 0, 0, "R1");
    drive(C1, 0, 0, "R1"); drive(NONE, 0, 0, "R1");
    clearSeq();

    // R4: enabled reset point discards progress
    cfgRstPtEn = 1'b1;
    drive(C3, 0, 0, "R4"); drive(C2, 0, 0, "R4"); drive(RP, 0, 0, "R4");
    drive(C1, 0, 0, "R4"); drive(C3, 0, 0, "R4"); drive(C2, 0, 0, "R4");
    drive(C1 | RP, 0, 0, "R4"); drive(C1, 0, 0, "R4");
    drive(C3, 0, 0, "R4"); drive(C2, 0, 0, "R4"); drive(C1, 1, 0, "R4");
    // R4: disabled reset point has no effect
    @(negedge clk); cfgRstPtEn = 1'b0;
    drive(C3, 0, 0, "R4"); drive(C2, 0, 0, "R4"); drive(RP, 0, 0, "R4");
    drive(C1, 1, 0, "R4"); drive(NONE, 0, 0, "R4");

    // R2 + R6: two-stage, trace-halt action
    @(negedge clk); cfgMode = 2'd2; cfgAction = 1'b1;
    drive(C3, 0, 0, "R2"); drive(C1, 0, 0, "R2"); drive(C2, 0, 0, "R2");
    drive(C3, 0, 0, "R2"); drive(C1, 0, 1, "R2/R6"); drive(NONE, 0, 0, "R6");

    // R5: repeat count three, then zero
    @(negedge clk); cfgAction = 1'b0; cfgRepeat = 8'd3;
    drive(C2, 0, 0, "R5"); drive(C1, 0, 0, "R5");
    drive(C2, 0, 0, "R5"); drive(C1, 0, 0, "R5");
    cfgRstPtEn = 1'b1;
    drive(C2, 0, 0, "R5"); drive(RP, 0, 0, "R5");  // keeps the count
    drive(C2, 0, 0, "R5"); drive(C1, 1, 0, "R5"); drive(NONE, 0, 0, "R5");
    @(negedge clk); cfgRstPtEn = 1'b0; cfgRepeat = 8'd0;
    drive(C2, 0, 0, "R5"); drive(C1, 1, 0, "R5"); drive(NONE, 0, 0, "R5");

    // R7: system reset masks a coincident match and clears progress
    @(negedge clk); cfgMode = 2'd1; cfgRepeat = 8'd1;
    drive(C3, 0, 0, "R7"); drive(C2, 0, 0, "R7"); drive(C1 | SR, 0, 0, "R7");
    drive(C1, 0, 0, "R7"); drive(NONE, 0, 0, "R7");
    // R7: count cleared by system reset
    @(negedge clk); cfgRepeat = 8'd2;
    drive(C3, 0, 0, "R7"); drive(C2, 0, 0, "R7"); drive(C1, 0, 0, "R7");
    drive(SR, 0, 0, "R7");
    drive(C3, 0, 0, "R7"); drive(C2, 0, 0, "R7"); drive(C1, 0, 0, "R7");
    drive(C3, 0, 0, "R7"); drive(C2, 0, 0, "R7"); drive(C1, 1, 0, "R7");

    // R8: rewrite flag masks matches but keeps progress
    @(negedge clk); cfgRepeat = 8'd1;
    drive(C3, 0, 0, "R8"); drive(C2, 0, 0, "R8"); drive(C1 | UP, 0, 0, "R8");
    drive(C3 | UP | RP, 0, 0, "R8"); drive(C1, 1, 0, "R8"); drive(NONE, 0, 0, "R8");

    // R9: modes 0 and 3 are off
    @(negedge clk); cfgMode = 2'd0;
    drive(C3, 0, 0, "R9"); drive(C2, 0, 0, "R9"); drive(C1, 0, 0, "R9");
    @(negedge clk); cfgMode = 2'd3;
    drive(C3, 0, 0, "R9"); drive(C2, 0, 0, "R9"); drive(C1, 0, 0, "R9");
    drive(NONE, 0, 0, "R9");
    // R9: progress held cleared while off
    @(negedge clk); cfgMode = 2'd1;
    drive(C2, 0, 0, "R9"); drive(C1, 0, 0, "R9"); drive(NONE, 0, 0, "R9");

    @(posedge clk); #2;
    @(posedge clk); #2;
    summary();
  end

endmodule